// File: doc/BRIEF.md
# Converter Serial Output Interface

This block is the device-side logic of an 18-bit converter's serial port when the port runs in three-wire chip-select mode. The host drives a convert strobe, a serial clock and a select line. A rising convert strobe samples the select line to choose the port mode, starts a conversion and takes the data line off the bus. The converter core returns a one-cycle done pulse together with the result word. The block then waits for the convert strobe to fall. When it does, the block drives the result onto the data line MSB first and moves one bit on each falling serial clock edge.

The block has no tri-state pad of its own. It gives a data bit and a separate output enable, and the pad ring or the bench builds the three-state line from the pair. All three host lines come in asynchronously. Each passes through a synchronizer of parameter depth, and the block detects edges on the system clock. The host must therefore hold each level for longer than the synchronizer latency.

Top module: `conv_serial_port`

## Requirements
- R1: After reset, and whenever the output enable is low, `sdoEn` is 0 and `sdoData` is 0.
- R2: The level of `sdiIn` on a rising `cnvIn` selects the mode: 1 selects three-wire chip-select mode. With 0, the output enable stays low for that whole conversion and the serial clock has no effect.
- R3: A rising `cnvIn` that arrives outside a conversion drops `sdoEn` and starts a new conversion, even in the middle of a read.
- R4: While a conversion runs, edges on `cnvIn` are ignored: the conversion does not restart and the mode is not sampled again. The mode chosen at the first rising edge still applies to the read that follows.
- R5: A `convDone` pulse during a conversion stores `convResult`. The next falling `cnvIn` raises `sdoEn` and puts bit D17 on `sdoData`.
- R6: Each falling `sckIn` edge while enabled moves `sdoData` to the next lower bit, so the bits appear D17 first and D0 last.
- R7: `sdoEn` stays high after the 17th falling `sckIn` edge with D0 shown, and drops on the 18th. Later `sckIn` edges leave it low.
- R8: If `cnvIn` falls before `convDone`, the output stays disabled. A later `convDone` does not enable it, and `sckIn` edges shift nothing out.
- R9: Every read starts at D17 with a fresh bit count, including a read that follows a read cut short by a rising `cnvIn`.
- R10: The outputs respond to an input edge on the third rising `clk` edge after the input changes, with the default of two synchronizer stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cnvIn | input | 1 | Convert strobe / chip select from host, asynchronous |
| sckIn | input | 1 | Serial clock from host, asynchronous |
| sdiIn | input | 1 | Mode-select level, sampled on rising `cnvIn` |
| convDone | input | 1 | One-cycle pulse from converter core, synchronous to `clk` |
| convResult | input | DATA_W | Conversion result, valid with `convDone` |
| sdoData | output | 1 | Serial data bit, 0 while disabled |
| sdoEn | output | 1 | Output enable for the three-state data line |

## Verification
The properties assume that `convDone` is a single-cycle pulse in the `clk` domain. They also assume that each level of `cnvIn`, `sckIn` and `sdiIn` lasts longer than the synchronizer plus the edge register, so the detected edges are clean and never come in the same cycle as the opposite edge. `sdiIn` is taken to change together with, or before, the rising `cnvIn` it qualifies. The bench changes host lines only on falling `clk` edges and holds every level for at least five clock cycles. It issues `convDone` only after the rising strobe has been registered.

// File: rtl/conv_serial_pkg.sv
package conv_serial_pkg;

  // Bit positions of the host lines inside the synchronizer bundle
  localparam int IDX_CNV = 0;
  localparam int IDX_SCK = 1;
  localparam int IDX_SDI = 2;
  localparam int HOST_LINES = 3;

  // Select-line level that chooses three-wire chip-select operation
  localparam logic MODE_3W = 1'b1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,  // acquisition, nothing to send
    ST_CONV  = 2'd1,  // conversion running, strobe ignored
    ST_READY = 2'd2,  // result held, waiting for strobe fall
    ST_SHIFT = 2'd3   // line driven, bits moving on serial clock
  } portStateT;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadWord;  // capture converter result
    logic clrCount;  // start a read at the top bit
    logic shiftOne;  // advance to next lower bit
  } dpStrobeT;

endpackage

// File: rtl/conv_serial_sync.sv
module conv_serial_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= '0;
    else       chain[0] <= asyncIn;
  end

  generate
    for (genvar g = 1; g < STAGES; g++) begin : gStage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[g] <= '0;
        else       chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign syncOut = chain[LAST];

endmodule

// File: rtl/conv_serial_ctrl.sv
module conv_serial_ctrl
  import conv_serial_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cnvLvl,
  input  logic     sckLvl,
  input  logic     sdiLvl,
  input  logic     convDone,
  input  logic     lastBit,
  output dpStrobeT strobe,
  output logic     sdoEn,
  output logic     cnvRise,
  output logic     cnvFall,
  output logic     sckFall
);

  portStateT state, stateNxt;
  logic      modeReg, modeNxt;
  logic      enReg, enNxt;
  logic      cnvPrev, sckPrev;

  // Edge detection on synchronized levels
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnvPrev <= 1'b0;
      sckPrev <= 1'b0;
    end else begin
      cnvPrev <= cnvLvl;
      sckPrev <= sckLvl;
    end
  end

  assign cnvRise = cnvLvl & ~cnvPrev;
  assign cnvFall = ~cnvLvl & cnvPrev;
  assign sckFall = ~sckLvl & sckPrev;

  always_comb begin
    stateNxt = state;
    modeNxt  = modeReg;
    enNxt    = enReg;
    strobe   = '0;

    unique case (state)
      ST_CONV: begin
        if (convDone) begin
          stateNxt        = ST_READY;
          strobe.loadWord = 1'b1;
        end
      end
      ST_READY: begin
        if (cnvFall) begin
          if (modeReg == MODE_3W) begin
            stateNxt        = ST_SHIFT;
            enNxt           = 1'b1;
            strobe.clrCount = 1'b1;
          end else begin
            stateNxt = ST_IDLE;
          end
        end
      end
      ST_SHIFT: begin
        if (sckFall) begin
          if (lastBit) begin
            stateNxt = ST_IDLE;
            enNxt    = 1'b0;
          end else begin
            strobe.shiftOne = 1'b1;
          end
        end
      end
      default: ;
    endcase

    // A new conversion overrides everything except a running one
    if (cnvRise && state != ST_CONV) begin
      stateNxt        = ST_CONV;
      modeNxt         = sdiLvl;
      enNxt           = 1'b0;
      strobe.shiftOne = 1'b0;
      strobe.clrCount = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      modeReg <= 1'b0;
      enReg   <= 1'b0;
    end else begin
      state   <= stateNxt;
      modeReg <= modeNxt;
      enReg   <= enNxt;
    end
  end

  assign sdoEn = enReg;

endmodule

// File: rtl/conv_serial_dpath.sv
module conv_serial_dpath
  import conv_serial_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          strobe,
  input  logic [DATA_W-1:0] convResult,
  output logic              msbOut,
  output logic              lastBit
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobe.loadWord) begin
      shiftReg <= convResult;
    end else if (strobe.shiftOne) begin
      shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (strobe.clrCount) begin
      bitCnt <= '0;
    end else if (strobe.shiftOne) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  assign msbOut  = shiftReg[DATA_W-1];
  assign lastBit = (bitCnt == LAST_IDX);

endmodule

// File: rtl/conv_serial_port.sv
module conv_serial_port
  import conv_serial_pkg::*;
#(
  parameter int DATA_W      = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cnvIn,
  input  logic              sckIn,
  input  logic              sdiIn,
  input  logic              convDone,
  input  logic [DATA_W-1:0] convResult,
  output logic              sdoData,
  output logic              sdoEn
);

  logic [HOST_LINES-1:0] hostRaw, hostLvl;
  dpStrobeT strobe;
  logic     msbOut, lastBit;
  logic     cnvRise, cnvFall, sckFall;

  always_comb begin
    hostRaw          = '0;
    hostRaw[IDX_CNV] = cnvIn;
    hostRaw[IDX_SCK] = sckIn;
    hostRaw[IDX_SDI] = sdiIn;
  end

  conv_serial_sync #(
    .WIDTH  (HOST_LINES),
    .STAGES (SYNC_STAGES)
  ) uSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (hostRaw),
    .syncOut (hostLvl)
  );

  conv_serial_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cnvLvl   (hostLvl[IDX_CNV]),
    .sckLvl   (hostLvl[IDX_SCK]),
    .sdiLvl   (hostLvl[IDX_SDI]),
    .convDone (convDone),
    .lastBit  (lastBit),
    .strobe   (strobe),
    .sdoEn    (sdoEn),
    .cnvRise  (cnvRise),
    .cnvFall  (cnvFall),
    .sckFall  (sckFall)
  );

  conv_serial_dpath #(
    .DATA_W (DATA_W)
  ) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .convResult (convResult),
    .msbOut     (msbOut),
    .lastBit    (lastBit)
  );

  assign sdoData = sdoEn & msbOut;

endmodule

// File: rtl/conv_serial_port_chk.sv
module conv_serial_port_chk #(
  parameter int DATA_W = 18
) (
  input logic clk,
  input logic rstN,
  input logic cnvRise,
  input logic cnvFall,
  input logic sckFall,
  input logic convDone,
  input logic sdoEn,
  input logic sdoData
);

  localparam int CW = $clog2(DATA_W + 1) + 1;

  logic [CW-1:0] fallCnt;
  logic          pendingConv;

  // Falling serial clock edges seen while the line is driven
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        fallCnt <= '0;
    else if (!sdoEn)  fallCnt <= '0;
    else if (sckFall) fallCnt <= fallCnt + 1'b1;
  end

  // A conversion is open from a rising strobe until done
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         pendingConv <= 1'b0;
    else if (convDone) pendingConv <= 1'b0;
    else if (cnvRise)  pendingConv <= 1'b1;
  end

  assert_rise_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    cnvRise |=> !sdoEn);

  assert_en_from_fall_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdoEn) |-> $past(cnvFall));

  assert_no_en_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    sdoEn |-> !pendingConv);

  assert_bit_limit_R7: assert property (@(posedge clk) disable iff (!rstN)
    sdoEn |-> (fallCnt < CW'(DATA_W)));

  assert_hold_between_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sdoEn && $past(sdoEn) && !$past(sckFall)) |-> $stable(sdoData));

endmodule

bind conv_serial_port conv_serial_port_chk #(.DATA_W(DATA_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .cnvRise  (cnvRise),
  .cnvFall  (cnvFall),
  .sckFall  (sckFall),
  .convDone (convDone),
  .sdoEn    (sdoEn),
  .sdoData  (sdoData)
);

// File: tb/tb_conv_serial_port.sv
module tb_conv_serial_port;

  localparam int W   = 18;
  localparam int LAT = 5;
  localparam logic [W-1:0] ALL1 = {W{1'b1}};

  typedef struct packed {
    logic [W-1:0] word;
    logic [4:0]   readLen;
  } vecT;

  localparam int NVEC = 6;
  localparam vecT VEC [NVEC] = '{
    '{18'h3FFFF, 5'd18},
    '{18'h15555, 5'd7},
    '{18'h2AAAA, 5'd18},
    '{18'h1E0F3, 5'd1},
    '{18'h20001, 5'd18},
    '{18'h00000, 5'd18}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cnvIn = 1'b0, sckIn = 1'b0, sdiIn = 1'b0, convDone = 1'b0;
  logic [W-1:0] convResult = '0;
  logic sdoData, sdoEn;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  conv_serial_port dut (
    .clk(clk), .rstN(rstN), .cnvIn(cnvIn), .sckIn(sckIn), .sdiIn(sdiIn),
    .convDone(convDone), .convResult(convResult),
    .sdoData(sdoData), .sdoEn(sdoEn)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cnvHigh(input logic sdiV);
    sdiIn = sdiV; cnvIn = 1'b1; tick(LAT);
  endtask

  task automatic cnvLow();
    cnvIn = 1'b0; tick(LAT);
  endtask

  task automatic sckPulse();
    sckIn = 1'b1; tick(LAT);
    sckIn = 1'b0; tick(LAT);
  endtask

  task automatic finishConv(input logic [W-1:0] w);
    convResult = w; convDone = 1'b1; tick(1);
    convDone = 1'b0; tick(1);
  endtask

  task automatic readBits(input int len, output logic [W-1:0] got);
    got = '0;
    for (int i = 0; i < len; i++) begin
      if (i > 0) sckPulse();
      got[W-1-i] = sdoData;
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    summary();
  end

  initial begin
    logic [W-1:0] got, mask;
    tick(3);
    check(sdoEn == 1'b0, "R1 reset enable", W'(sdoEn), '0);
    check(sdoData == 1'b0, "R1 reset data", W'(sdoData), '0);
    rstN = 1'b1; tick(2);

    // Vector table: convert, read, end by 18th edge or early strobe rise
    for (int v = 0; v < NVEC; v++) begin
      if (!cnvIn) cnvHigh(1'b1);
      finishConv(VEC[v].word);
      cnvLow();
      check(sdoEn == 1'b1, "R5 enable on strobe fall", W'(sdoEn), W'(1));
      readBits(int'(VEC[v].readLen), got);
      mask = ~(ALL1 >> VEC[v].readLen);
      check(got == (VEC[v].word & mask), "R6 R9 bit order from D17", got,
            VEC[v].word & mask);
      if (VEC[v].readLen == 5'd18) begin
        check(sdoEn == 1'b1, "R7 still on after 17 edges", W'(sdoEn), W'(1));
        sckPulse();
        check(sdoEn == 1'b0, "R7 off after 18th edge", W'(sdoEn), '0);
        sckPulse();
        check(sdoEn == 1'b0 && sdoData == 1'b0, "R7 extra clock ignored",
              W'({sdoEn, sdoData}), '0);
      end else begin
        cnvHigh(1'b1);
        check(sdoEn == 1'b0, "R3 rise cuts read", W'(sdoEn), '0);
      end
    end

    // R2: select low means no output for this conversion
    cnvHigh(1'b0);
    finishConv(ALL1);
    cnvLow();
    check(sdoEn == 1'b0, "R2 other mode no enable", W'(sdoEn), '0);
    check(sdoData == 1'b0, "R1 data low while off", W'(sdoData), '0);
    sckPulse();
    check(sdoEn == 1'b0, "R2 clock ignored", W'(sdoEn), '0);

    // R8: strobe falls before done
    cnvHigh(1'b1);
    cnvLow();
    check(sdoEn == 1'b0, "R8 off before done", W'(sdoEn), '0);
    finishConv(ALL1);
    check(sdoEn == 1'b0, "R8 done does not enable", W'(sdoEn), '0);
    sckPulse();
    check(sdoEn == 1'b0 && sdoData == 1'b0, "R8 no bits shifted",
          W'({sdoEn, sdoData}), '0);

    // R4: second rise with select low during conversion is ignored
    cnvHigh(1'b1);
    cnvLow();
    cnvHigh(1'b0);
    finishConv(18'h2D34A);
    cnvLow();
    check(sdoEn == 1'b1, "R4 mode kept through conversion", W'(sdoEn), W'(1));
    readBits(W, got);
    check(got == 18'h2D34A, "R4 result intact", got, 18'h2D34A);
    sckPulse();

    // R10: exact latency of a strobe fall
    cnvHigh(1'b1);
    finishConv(ALL1);
    cnvIn = 1'b0;
    tick(2);
    check(sdoEn == 1'b0, "R10 not yet after two edges", W'(sdoEn), '0);
    tick(1);
    check(sdoEn == 1'b1 && sdoData == 1'b1, "R10 on at third edge",
          W'({sdoEn, sdoData}), W'(3));
    tick(LAT);

    summary();
  end

endmodule